// File: doc/BRIEF.md
# Indexed-Address Register File

This block holds the eight 16-bit general registers of a small load/store core. It also contains the address generator for indexed memory operands. Results come only from registers and go only to registers. Register 0 is hardwired to zero: a result aimed at it is thrown away, while the flag-update enable from the core still passes straight through to the condition-code logic.

The source read port returns either a whole register or one of its two bytes, with the byte placed in the low eight bits. The result write port stores either a whole word or one byte lane, and the other lane is left as it was. The address side adds a base register to an offset register. In the two auto-update forms, the offset is stepped after the access or before it. The stepped offset goes back to the register file through a second write port. When the offset register is register 0, no update happens. A word access at an odd address raises a flag.

Top module: `rfx_regfile_agu`

## Requirements
- R1: A synchronous reset clears every register, so all registers read 0x0000 after reset.
- R2: Register 0 always reads 0x0000. A result written to register 0 is discarded.
- R3: Source read lane codes: 0 returns the full word, 1 returns {8'h00, bits[7:0]}, 2 returns {8'h00, bits[15:8]}, and 3 acts as 0. The read is combinational.
- R4: Result lane codes are the same as for reads. A word write stores all 16 bits. Lane 1 stores res_data[7:0] into bits [7:0], and lane 2 stores res_data[7:0] into bits [15:8]. The other byte is kept. The write takes effect at the next rising edge.
- R5: Index mode 0 (and the unused code 3) gives ea = base + offset and does not update the offset register.
- R6: Index mode 1 (post-increment) gives ea = base + offset. At the next edge the offset register becomes offset + step.
- R7: Index mode 2 (pre-decrement) computes offset' = offset - step and gives ea = base + offset'. At the next edge the offset register becomes offset'.
- R8: The step is 1 when idx_word = 0 and 2 when idx_word = 1. All address and offset arithmetic wraps modulo 2^16.
- R9: With off_sel = 0, modes 1 and 2 behave exactly like mode 0, and off_wb_fire stays low.
- R10: misalign is high exactly when idx_en = 1, idx_word = 1 and ea[0] = 1. It is never raised for byte accesses.
- R11: When a result write targets the same nonzero register as an active offset update, the result is stored and the offset update is dropped (off_wb_fire low). Writes to different registers both take effect in the same cycle.
- R12: cc_upd_out equals cc_upd_in for every destination, including register 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous reset, active high |
| src_sel | input | 3 | Source register number |
| src_lane | input | 2 | Source lane code |
| src_data | output | 16 | Source operand, byte lanes zero-extended |
| res_we | input | 1 | Result write enable |
| res_sel | input | 3 | Destination register number |
| res_lane | input | 2 | Destination lane code |
| res_data | input | 16 | Result value; bytes taken from bits [7:0] |
| cc_upd_in | input | 1 | Flag-update enable from the core |
| cc_upd_out | output | 1 | Flag-update enable to the flag logic |
| idx_en | input | 1 | Indexed access active this cycle |
| idx_mode | input | 2 | 0 plain, 1 post-increment, 2 pre-decrement |
| idx_word | input | 1 | 1 for word access, 0 for byte access |
| base_sel | input | 3 | Base register number |
| off_sel | input | 3 | Offset register number |
| ea | output | 16 | Effective address |
| misalign | output | 1 | Word access at odd address |
| off_wb_fire | output | 1 | Offset write-back happens at the next edge |

## Verification
Every address mode is run with both a byte step and a word step. This separates a step of 1 from a step of 2, and an access that uses the offset before the step from one that uses it after. Offsets near 0x0000 and 0xFFFF test the wrap in both directions. Register 0 is used as the offset and as the base, which shows whether the degenerate forms really skip the write-back. A result write to the same register as the offset update, and one to a different register, separate the collision rule from the two independent write ports. Byte-lane writes of distinct patterns show that the untouched byte is kept.

// File: rtl/rfx_pkg.sv
package rfx_pkg;
  typedef enum logic [1:0] {
    IX_PLAIN = 2'd0,
    IX_POST  = 2'd1,
    IX_PRE   = 2'd2,
    IX_RSVD  = 2'd3
  } ix_mode_e;

  typedef enum logic [1:0] {
    LN_WORD = 2'd0,
    LN_LO   = 2'd1,
    LN_HI   = 2'd2,
    LN_RSVD = 2'd3
  } lane_e;
endpackage

// File: rtl/rfx_regbank.sv
module rfx_regbank #(
  parameter int unsigned NREG = 8,
  parameter int unsigned DW   = 16,
  localparam int unsigned AW  = $clog2(NREG),
  localparam int unsigned NB  = DW / 8
) (
  input  logic          clk,
  input  logic          rst,
  input  logic [AW-1:0] rsel_src,
  input  logic [AW-1:0] rsel_base,
  input  logic [AW-1:0] rsel_off,
  output logic [DW-1:0] rval_src,
  output logic [DW-1:0] rval_base,
  output logic [DW-1:0] rval_off,
  // port A: results, byte enables
  input  logic          pa_en,
  input  logic [AW-1:0] pa_sel,
  input  logic [NB-1:0] pa_be,
  input  logic [DW-1:0] pa_data,
  // port B: offset write-back, full word
  input  logic          pb_en,
  input  logic [AW-1:0] pb_sel,
  input  logic [DW-1:0] pb_data
);
  logic [DW-1:0] regs [NREG];

  function automatic logic [DW-1:0] fetch(input logic [AW-1:0] sel,
                                          input logic [DW-1:0] val);
    return (sel == '0) ? '0 : val;
  endfunction

  assign rval_src  = fetch(rsel_src,  regs[rsel_src]);
  assign rval_base = fetch(rsel_base, regs[rsel_base]);
  assign rval_off  = fetch(rsel_off,  regs[rsel_off]);

  always_ff @(posedge clk) begin
    if (rst) begin
      for (int i = 0; i < NREG; i++) regs[i] <= '0;
    end else begin
      for (int i = 1; i < NREG; i++) begin
        if (pa_en && pa_sel == AW'(i)) begin
          for (int b = 0; b < NB; b++)
            if (pa_be[b]) regs[i][b*8 +: 8] <= pa_data[b*8 +: 8];
        end else if (pb_en && pb_sel == AW'(i)) begin
          regs[i] <= pb_data;
        end
      end
    end
  end

  // R11: the two ports never aim at the same register in one cycle
  p_ports_disjoint_r11: assert property (@(posedge clk) disable iff (rst)
    (pa_en && pb_en) |-> (pa_sel != pb_sel));
endmodule

// File: rtl/rfx_lane.sv
module rfx_lane #(
  parameter int unsigned DW = 16,
  localparam int unsigned NB = DW / 8
) (
  input  rfx_pkg::lane_e rd_lane,
  input  logic [DW-1:0]  rd_word,
  output logic [DW-1:0]  rd_out,
  input  rfx_pkg::lane_e wr_lane,
  input  logic [DW-1:0]  wr_val,
  output logic [DW-1:0]  wr_word,
  output logic [NB-1:0]  wr_be
);
  import rfx_pkg::*;

  function automatic logic [DW-1:0] pick(input lane_e ln, input logic [DW-1:0] w);
    case (ln)
      LN_LO:   return {{(DW-8){1'b0}}, w[7:0]};
      LN_HI:   return {{(DW-8){1'b0}}, w[DW-1 -: 8]};
      default: return w;
    endcase
  endfunction

  function automatic logic [DW-1:0] place(input lane_e ln, input logic [DW-1:0] v);
    case (ln)
      LN_LO:   return {{(DW-8){1'b0}}, v[7:0]};
      LN_HI:   return {v[7:0], {(DW-8){1'b0}}};
      default: return v;
    endcase
  endfunction

  function automatic logic [NB-1:0] enables(input lane_e ln);
    case (ln)
      LN_LO:   return NB'(1);
      LN_HI:   return NB'(1) << (NB - 1);
      default: return '1;
    endcase
  endfunction

  assign rd_out  = pick(rd_lane, rd_word);
  assign wr_word = place(wr_lane, wr_val);
  assign wr_be   = enables(wr_lane);
endmodule

// File: rtl/rfx_agu.sv
module rfx_agu #(
  parameter int unsigned DW = 16
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             en,
  input  rfx_pkg::ix_mode_e mode,
  input  logic             is_word,
  input  logic             off_nz,
  input  logic [DW-1:0]    base,
  input  logic [DW-1:0]    off,
  output logic [DW-1:0]    ea,
  output logic [DW-1:0]    off_next,
  output logic             upd,
  output logic             misalign
);
  import rfx_pkg::*;

  function automatic logic [DW-1:0] step_of(input logic w);
    return w ? DW'(2) : DW'(1);
  endfunction

  function automatic logic [DW-1:0] stepped(input ix_mode_e m, input logic [DW-1:0] o,
                                            input logic [DW-1:0] s);
    case (m)
      IX_POST: return o + s;
      IX_PRE:  return o - s;
      default: return o;
    endcase
  endfunction

  logic          mode_upd;
  logic [DW-1:0] used_off;

  assign mode_upd = (mode == IX_POST) || (mode == IX_PRE);
  assign upd      = en && mode_upd && off_nz;
  assign off_next = stepped(mode, off, step_of(is_word));
  assign used_off = (mode == IX_PRE && off_nz) ? off_next : off;
  assign ea       = base + used_off;
  assign misalign = en && is_word && ea[0];

  // R10: byte accesses are never flagged
  p_byte_aligned_r10: assert property (@(posedge clk) disable iff (rst)
    (en && !is_word) |-> !misalign);
endmodule

// File: rtl/rfx_regfile_agu.sv
module rfx_regfile_agu #(
  parameter int unsigned NREG = 8,
  parameter int unsigned DW   = 16,
  localparam int unsigned AW  = $clog2(NREG),
  localparam int unsigned NB  = DW / 8
) (
  input  logic          clk,
  input  logic          rst,
  input  logic [AW-1:0] src_sel,
  input  logic [1:0]    src_lane,
  output logic [DW-1:0] src_data,
  input  logic          res_we,
  input  logic [AW-1:0] res_sel,
  input  logic [1:0]    res_lane,
  input  logic [DW-1:0] res_data,
  input  logic          cc_upd_in,
  output logic          cc_upd_out,
  input  logic          idx_en,
  input  logic [1:0]    idx_mode,
  input  logic          idx_word,
  input  logic [AW-1:0] base_sel,
  input  logic [AW-1:0] off_sel,
  output logic [DW-1:0] ea,
  output logic          misalign,
  output logic          off_wb_fire
);
  import rfx_pkg::*;

  logic [DW-1:0] raw_src, raw_base, raw_off, off_next, res_word;
  logic [NB-1:0] res_be;
  logic          agu_upd, res_hits_off;

  assign cc_upd_out   = cc_upd_in;
  assign res_hits_off = res_we && (res_sel == off_sel);
  assign off_wb_fire  = agu_upd && !res_hits_off;

  rfx_lane #(.DW(DW)) u_lane (
    .rd_lane (lane_e'(src_lane)),
    .rd_word (raw_src),
    .rd_out  (src_data),
    .wr_lane (lane_e'(res_lane)),
    .wr_val  (res_data),
    .wr_word (res_word),
    .wr_be   (res_be)
  );

  rfx_agu #(.DW(DW)) u_agu (
    .clk      (clk),
    .rst      (rst),
    .en       (idx_en),
    .mode     (ix_mode_e'(idx_mode)),
    .is_word  (idx_word),
    .off_nz   (off_sel != '0),
    .base     (raw_base),
    .off      (raw_off),
    .ea       (ea),
    .off_next (off_next),
    .upd      (agu_upd),
    .misalign (misalign)
  );

  rfx_regbank #(.NREG(NREG), .DW(DW)) u_bank (
    .clk       (clk),
    .rst       (rst),
    .rsel_src  (src_sel),
    .rsel_base (base_sel),
    .rsel_off  (off_sel),
    .rval_src  (raw_src),
    .rval_base (raw_base),
    .rval_off  (raw_off),
    .pa_en     (res_we),
    .pa_sel    (res_sel),
    .pa_be     (res_be),
    .pa_data   (res_word),
    .pb_en     (off_wb_fire),
    .pb_sel    (off_sel),
    .pb_data   (off_next)
  );

  // R2: register 0 reads as zero in every lane
  p_r0_reads_zero_r2: assert property (@(posedge clk) disable iff (rst)
    (src_sel == '0) |-> (src_data == '0));
  // R9: offset register 0 never gets a write-back
  p_r0_offset_quiet_r9: assert property (@(posedge clk) disable iff (rst)
    (off_sel == '0) |-> !off_wb_fire);
  // R11: loaded data wins over the offset update
  p_load_wins_r11: assert property (@(posedge clk) disable iff (rst)
    (idx_en && res_we && res_sel == off_sel) |-> !off_wb_fire);
  // R12: flag enable passes through unchanged
  p_flag_follow_r12: assert property (@(posedge clk) disable iff (rst)
    (res_we && res_sel == '0) |-> (cc_upd_out == cc_upd_in));
endmodule

// File: tb/tb_rfx_regfile_agu.sv
`timescale 1ns/1ps
module tb_rfx_regfile_agu;
  logic        clk = 0, rst = 1;
  logic [2:0]  src_sel = 0, res_sel = 0, base_sel = 0, off_sel = 0;
  logic [1:0]  src_lane = 0, res_lane = 0, idx_mode = 0;
  logic [15:0] res_data = 0;
  logic        res_we = 0, cc_upd_in = 0, idx_en = 0, idx_word = 0;
  logic [15:0] src_data, ea;
  logic        cc_upd_out, misalign, off_wb_fire;
  int checks = 0, failures = 0;

  always #2.5 clk = ~clk;

  rfx_regfile_agu dut (.*);

  task automatic chk(input string req, input logic [15:0] act, input logic [15:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic rd(input logic [2:0] s, input logic [1:0] ln, output logic [15:0] v);
    src_sel = s; src_lane = ln; #1; v = src_data;
  endtask

  task automatic wr(input logic [2:0] s, input logic [1:0] ln, input logic [15:0] v);
    @(negedge clk); res_we = 1; res_sel = s; res_lane = ln; res_data = v;
    @(negedge clk); res_we = 0;
  endtask

  // one indexed access; checks ea, misalign and write-back fire
  task automatic ix(input string req, input logic [1:0] m, input logic w,
                    input logic [2:0] b, input logic [2:0] o,
                    input logic [15:0] exp_ea, input logic exp_mis, input logic exp_fire);
    @(negedge clk); idx_en = 1; idx_mode = m; idx_word = w; base_sel = b; off_sel = o;
    #1;
    chk(req, ea, exp_ea);
    chk({req, " misalign"}, 16'(misalign), 16'(exp_mis));
    chk({req, " fire"}, 16'(off_wb_fire), 16'(exp_fire));
    @(negedge clk); idx_en = 0;
  endtask

  task automatic t_reset;
    logic [15:0] v;
    for (int i = 0; i < 8; i++) begin
      rd(3'(i), 2'd0, v); chk("R1 reset clear", v, 16'h0);
    end
  endtask

  task automatic t_r0;
    logic [15:0] v;
    cc_upd_in = 1;
    @(negedge clk); res_we = 1; res_sel = 0; res_lane = 0; res_data = 16'h1234;
    #1; chk("R12 flag enable high on R0", 16'(cc_upd_out), 16'h1);
    cc_upd_in = 0; #1; chk("R12 flag enable low on R0", 16'(cc_upd_out), 16'h0);
    @(negedge clk); res_we = 0;
    rd(0, 0, v); chk("R2 R0 discard", v, 16'h0);
    rd(0, 2, v); chk("R2 R0 high lane", v, 16'h0);
  endtask

  task automatic t_lanes;
    logic [15:0] v;
    wr(3, 0, 16'hA55A);
    rd(3, 0, v); chk("R3 word read", v, 16'hA55A);
    rd(3, 1, v); chk("R3 low read", v, 16'h005A);
    rd(3, 2, v); chk("R3 high read", v, 16'h00A5);
    rd(3, 3, v); chk("R3 code 3 read", v, 16'hA55A);
    wr(3, 1, 16'hFF77); rd(3, 0, v); chk("R4 low write keeps high", v, 16'hA577);
    wr(3, 2, 16'hEE11); rd(3, 0, v); chk("R4 high write keeps low", v, 16'h1177);
  endtask

  task automatic t_modes;
    logic [15:0] v;
    wr(1, 0, 16'h1000); wr(2, 0, 16'h0004);
    ix("R5 plain", 0, 1, 1, 2, 16'h1004, 0, 0); rd(2, 0, v); chk("R5 no update", v, 16'h0004);
    ix("R5 code 3", 3, 1, 1, 2, 16'h1004, 0, 0); rd(2, 0, v); chk("R5 code 3 no update", v, 16'h0004);
    ix("R6 post byte", 1, 0, 1, 2, 16'h1004, 0, 1); rd(2, 0, v); chk("R8 step 1", v, 16'h0005);
    ix("R6 post word", 1, 1, 1, 2, 16'h1005, 1, 1); rd(2, 0, v); chk("R8 step 2", v, 16'h0007);
    ix("R7 pre word", 2, 1, 1, 2, 16'h1005, 1, 1); rd(2, 0, v); chk("R7 pre word wb", v, 16'h0005);
    ix("R7 pre byte", 2, 0, 1, 2, 16'h1004, 0, 1); rd(2, 0, v); chk("R7 pre byte wb", v, 16'h0004);
    ix("R10 odd byte", 2, 0, 1, 2, 16'h1003, 0, 1); rd(2, 0, v); chk("R7 odd byte wb", v, 16'h0003);
    ix("R10 R0 base word", 0, 1, 0, 2, 16'h0003, 1, 0);
  endtask

  task automatic t_wrap;
    logic [15:0] v;
    wr(4, 0, 16'hFFFF);
    ix("R8 wrap post", 1, 1, 1, 4, 16'h0FFF, 1, 1); rd(4, 0, v); chk("R8 wrap up", v, 16'h0001);
    wr(5, 0, 16'h0000);
    ix("R8 wrap pre", 2, 0, 1, 5, 16'h0FFF, 0, 1); rd(5, 0, v); chk("R8 wrap down", v, 16'hFFFF);
  endtask

  task automatic t_r0_offset;
    ix("R9 post R0", 1, 1, 1, 0, 16'h1000, 0, 0);
    ix("R9 pre R0", 2, 1, 1, 0, 16'h1000, 0, 0);
  endtask

  task automatic t_collide;
    logic [15:0] v;
    @(negedge clk); idx_en = 1; idx_mode = 1; idx_word = 0; base_sel = 1; off_sel = 2;
    res_we = 1; res_sel = 2; res_lane = 0; res_data = 16'hBEEF;
    #1; chk("R11 collision fire", 16'(off_wb_fire), 16'h0);
    @(negedge clk); idx_en = 0; res_we = 0;
    rd(2, 0, v); chk("R11 load wins", v, 16'hBEEF);
    @(negedge clk); idx_en = 1; idx_mode = 1; idx_word = 1; base_sel = 1; off_sel = 2;
    res_we = 1; res_sel = 6; res_lane = 0; res_data = 16'h0606;
    #1; chk("R11 disjoint fire", 16'(off_wb_fire), 16'h1);
    @(negedge clk); idx_en = 0; res_we = 0;
    rd(2, 0, v); chk("R11 offset port", v, 16'hBEF1);
    rd(6, 0, v); chk("R11 result port", v, 16'h0606);
    @(negedge clk); idx_en = 0; idx_mode = 1; idx_word = 1; off_sel = 2; base_sel = 1;
    #1; chk("R10 idle no misalign", 16'(misalign), 16'h0);
    @(negedge clk); rd(2, 0, v); chk("R6 idle no update", v, 16'hBEF1);
  endtask

  initial begin
    fork
      begin
        repeat (3) @(negedge clk);
        rst = 0;
        t_reset(); t_r0(); t_lanes(); t_modes(); t_wrap(); t_r0_offset(); t_collide();
      end
      begin
        repeat (20000) @(posedge clk);
        failures++;
        $display("FAIL watchdog expired");
      end
    join_any
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule